// File: doc/BRIEF.md
# Serial Display Command and Pixel Framer

This block is the transmit side of a write-only serial link to a display controller. A host hands it requests over a valid/ready port. It turns each request into framed serial words on chip select, serial clock and data-out, and it raises a one-cycle completion pulse when the link is idle again. Each word carries a leading marker byte. The receiving controller uses that byte to tell a register index from register data or pixel data.

There are four request kinds. An index write and a data write each send a single 16-bit frame. A register write sends an index frame and then a data frame, and each of the two has its own chip-select window. A pixel burst sends one 8-bit start marker and then a host-supplied number of 16-bit colour words, with chip select held low from the first bit to the last. Colour words come in on a second valid/ready port. A per-request divider input sets the serial clock speed.

Top module: `spi_lcd_framer`

## Requirements
- R1: Request kind 0 (index write) sends one 16-bit frame, MSB first, whose upper byte is 0x70 and whose lower byte is req_arg[7:0].
- R2: Request kind 1 (data write) sends one 16-bit frame, MSB first, whose upper byte is 0x72 and whose lower byte is req_arg[7:0].
- R3: The link runs in mode 3. sck is high whenever cs_n is high. mosi changes only while sck falls and holds steady across every rising edge of sck.
- R4: cs_n goes low before the first falling edge of sck in a frame. It returns high only after the last rising edge. A 16-bit frame shows exactly 16 rising edges inside one cs_n low window.
- R5: Request kind 2 (register write) sends two cs_n windows. The first carries 0x70 with req_arg[15:8]. The second carries 0x72 with req_arg[7:0].
- R6: Request kind 3 (pixel burst) keeps cs_n low for one window. In that window it sends the 8-bit byte 0x72 and then req_arg 16-bit words taken from px_data. px_ready is high only while words are still owed. A count of zero sends the start byte alone.
- R7: Between two frames of one request, cs_n stays high for at least two half-periods (one full sck period).
- R8: Each sck half-period lasts half_per system clocks, and a value of 0 acts as 1. half_per is captured when a request is accepted, so later changes do not affect a transfer already under way.
- R9: busy rises on acceptance and falls only after cs_n has returned high. req_ready is high only while busy is low. done is a single-cycle pulse at the end of each request.
- R10: After reset, cs_n and sck are high, busy and px_ready are low, and req_ready is high.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous active-high reset |
| req_valid | input | 1 | Request offered |
| req_ready | output | 1 | Framer can take a request |
| req_kind | input | 2 | 0 index, 1 data, 2 register write, 3 pixel burst |
| req_arg | input | 16 | Index/value byte(s), or burst word count |
| half_per | input | DIV_W | sck half-period in system clocks |
| px_valid | input | 1 | Colour word offered |
| px_ready | output | 1 | Colour word taken this cycle if valid |
| px_data | input | 16 | Colour word |
| sck | output | 1 | Serial clock, idles high |
| mosi | output | 1 | Serial data out |
| cs_n | output | 1 | Active-low chip select |
| busy | output | 1 | Request in progress |
| done | output | 1 | Request finished pulse |

## Verification
The bench checks the register write closely. If a design merged its two frames into one window, it would show one 32-bit window rather than two 16-bit ones. If it shortened the chip-select gap, the measured high time between windows would fall below two half-periods. Bursts of zero and of several words are both run: a design with an off-by-one in the word count would leave px_ready high one extra time or drop a word from the captured stream. Half-periods of 0 and 3 are tested, and half_per is also changed in the middle of a transfer. A design that read the live divider input, or that let zero mean zero, would produce the wrong measured sck low time.

// File: rtl/lcdf_pkg.sv
package lcdf_pkg;
  typedef enum logic [1:0] {
    K_INDEX = 2'd0,
    K_DATA  = 2'd1,
    K_REGWR = 2'd2,
    K_BURST = 2'd3
  } req_kind_t;

  typedef enum logic [2:0] {
    S_IDLE, S_SETUP, S_SHIFT, S_PXWAIT, S_HOLD, S_GAP
  } seq_state_t;

  localparam logic [7:0] PFX_INDEX = 8'h70;
  localparam logic [7:0] PFX_DATA  = 8'h72;
endpackage

// File: rtl/lcdf_tick.sv
module lcdf_tick #(
  parameter int DIV_W = 8
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             run,
  input  logic [DIV_W-1:0] half,
  output logic             tick
);
  logic [DIV_W-1:0] cnt;
  logic [DIV_W-1:0] lim;

  // a half-period of zero behaves as one system clock
  always_comb lim = (half == '0) ? '0 : half - DIV_W'(1);

  always_ff @(posedge clk) begin
    if (rst || !run) begin
      cnt  <= '0;
      tick <= 1'b0;
    end else if (cnt >= lim) begin
      cnt  <= '0;
      tick <= 1'b1;
    end else begin
      cnt  <= cnt + DIV_W'(1);
      tick <= 1'b0;
    end
  end
endmodule

// File: rtl/lcdf_shift.sv
module lcdf_shift #(
  parameter int WORD_W = 16,
  localparam int BC_W  = $clog2(WORD_W + 1)
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              tick,
  input  logic              load,
  input  logic [WORD_W-1:0] word,   // left aligned
  input  logic [BC_W-1:0]   nbits,
  output logic              sck,
  output logic              mosi,
  output logic              idle,
  output logic              fin
);
  logic [WORD_W-1:0] sr;
  logic [BC_W-1:0]   left;
  logic              act;
  logic              ph;    // 0: next tick drops sck, 1: next tick raises it

  always_ff @(posedge clk) begin
    if (rst) begin
      sr   <= '0;
      left <= '0;
      act  <= 1'b0;
      ph   <= 1'b0;
      sck  <= 1'b1;
      mosi <= 1'b0;
      fin  <= 1'b0;
    end else begin
      fin <= 1'b0;
      if (load && !act) begin
        sr   <= word;
        left <= nbits;
        act  <= 1'b1;
        ph   <= 1'b0;
      end else if (act && tick) begin
        if (!ph) begin
          sck  <= 1'b0;
          mosi <= sr[WORD_W-1];
          sr   <= {sr[WORD_W-2:0], 1'b0};
          ph   <= 1'b1;
        end else begin
          sck  <= 1'b1;
          ph   <= 1'b0;
          left <= left - BC_W'(1);
          if (left == BC_W'(1)) begin
            act <= 1'b0;
            fin <= 1'b1;
          end
        end
      end
    end
  end

  assign idle = !act;
endmodule

// File: rtl/spi_lcd_framer.sv
module spi_lcd_framer
  import lcdf_pkg::*;
#(
  parameter int DIV_W = 8,
  parameter int ARG_W = 16
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             req_valid,
  output logic             req_ready,
  input  logic [1:0]       req_kind,
  input  logic [ARG_W-1:0] req_arg,
  input  logic [DIV_W-1:0] half_per,
  input  logic             px_valid,
  output logic             px_ready,
  input  logic [15:0]      px_data,
  output logic             sck,
  output logic             mosi,
  output logic             cs_n,
  output logic             busy,
  output logic             done
);
  localparam int WORD_W = 16;
  localparam int BC_W   = $clog2(WORD_W + 1);

  seq_state_t       st;
  req_kind_t        kind_q;
  logic [ARG_W-1:0] arg_q;
  logic [ARG_W-1:0] left_q;
  logic [DIV_W-1:0] half_q;
  logic             pend_q, gap_q, cs_q, busy_q, done_q;

  logic              tick, sh_load, sh_idle, sh_fin;
  logic [WORD_W-1:0] sh_word;
  logic [BC_W-1:0]   sh_bits;

  lcdf_tick #(.DIV_W(DIV_W)) u_tick (
    .clk(clk), .rst(rst), .run(st != S_IDLE), .half(half_q), .tick(tick)
  );

  lcdf_shift #(.WORD_W(WORD_W)) u_shift (
    .clk(clk), .rst(rst), .tick(tick), .load(sh_load), .word(sh_word),
    .nbits(sh_bits), .sck(sck), .mosi(mosi), .idle(sh_idle), .fin(sh_fin)
  );

  // frame selection: the marker byte depends on kind and frame position
  always_comb begin
    sh_word = '0;
    sh_bits = BC_W'(WORD_W);
    if (st == S_PXWAIT) begin
      sh_word = px_data;
    end else begin
      case (kind_q)
        K_INDEX: sh_word = {PFX_INDEX, arg_q[7:0]};
        K_DATA:  sh_word = {PFX_DATA, arg_q[7:0]};
        K_REGWR: sh_word = pend_q ? {PFX_INDEX, arg_q[15:8]} : {PFX_DATA, arg_q[7:0]};
        default: begin
          sh_word = {PFX_DATA, 8'h00};
          sh_bits = BC_W'(8);
        end
      endcase
    end
  end

  assign sh_load   = ((st == S_SETUP) && tick) || ((st == S_PXWAIT) && px_valid && sh_idle);
  assign req_ready = (st == S_IDLE);
  assign px_ready  = (st == S_PXWAIT) && sh_idle;

  always_ff @(posedge clk) begin
    if (rst) begin
      st     <= S_IDLE;
      kind_q <= K_INDEX;
      arg_q  <= '0;
      left_q <= '0;
      half_q <= '0;
      pend_q <= 1'b0;
      gap_q  <= 1'b0;
      cs_q   <= 1'b1;
      busy_q <= 1'b0;
      done_q <= 1'b0;
    end else begin
      done_q <= 1'b0;
      case (st)
        S_IDLE: if (req_valid) begin
          kind_q <= req_kind_t'(req_kind);
          arg_q  <= req_arg;
          half_q <= half_per;
          pend_q <= (req_kind_t'(req_kind) == K_REGWR);
          left_q <= (req_kind_t'(req_kind) == K_BURST) ? req_arg : '0;
          cs_q   <= 1'b0;
          busy_q <= 1'b1;
          st     <= S_SETUP;
        end
        S_SETUP: if (tick) st <= S_SHIFT;
        S_SHIFT: if (sh_fin) begin
          st <= ((kind_q == K_BURST) && (left_q != '0)) ? S_PXWAIT : S_HOLD;
        end
        S_PXWAIT: if (px_valid && sh_idle) begin
          left_q <= left_q - ARG_W'(1);
          st     <= S_SHIFT;
        end
        S_HOLD: if (tick) begin
          cs_q  <= 1'b1;
          gap_q <= 1'b0;
          st    <= S_GAP;
        end
        S_GAP: if (tick) begin
          if (!gap_q) begin
            gap_q <= 1'b1;
          end else if (pend_q) begin
            pend_q <= 1'b0;
            cs_q   <= 1'b0;
            st     <= S_SETUP;
          end else begin
            busy_q <= 1'b0;
            done_q <= 1'b1;
            st     <= S_IDLE;
          end
        end
        default: st <= S_IDLE;
      endcase
    end
  end

  assign cs_n = cs_q;
  assign busy = busy_q;
  assign done = done_q;
endmodule

// File: rtl/spi_lcd_framer_chk.sv
module spi_lcd_framer_chk (
  input logic clk,
  input logic rst,
  input logic req_ready,
  input logic px_ready,
  input logic sck,
  input logic mosi,
  input logic cs_n,
  input logic busy,
  input logic done
);
  a_r3_sck_idle_high: assert property (@(posedge clk) disable iff (rst)
    cs_n |-> sck);
  a_r3_mosi_steady: assert property (@(posedge clk) disable iff (rst)
    $rose(sck) |-> $stable(mosi));
  a_r9_idle_deselect: assert property (@(posedge clk) disable iff (rst)
    !busy |-> cs_n);
  a_r9_ready_only_idle: assert property (@(posedge clk) disable iff (rst)
    req_ready |-> !busy);
  a_r9_done_single: assert property (@(posedge clk) disable iff (rst)
    done |=> !done);
  a_r6_pixel_in_window: assert property (@(posedge clk) disable iff (rst)
    px_ready |-> (!cs_n && busy));
  a_r7_cs_gap_min: assert property (@(posedge clk) disable iff (rst)
    $rose(cs_n) |=> cs_n);
endmodule

bind spi_lcd_framer spi_lcd_framer_chk u_chk (
  .clk(clk), .rst(rst), .req_ready(req_ready), .px_ready(px_ready),
  .sck(sck), .mosi(mosi), .cs_n(cs_n), .busy(busy), .done(done)
);

// File: tb/sim_spi_lcd_framer.sv
module sim_spi_lcd_framer;
  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic        req_valid = 1'b0;
  logic [1:0]  req_kind = 2'd0;
  logic [15:0] req_arg = 16'h0;
  logic [7:0]  half_per = 8'd1;
  logic        px_valid = 1'b0;
  logic [15:0] px_data = 16'h0;
  logic        req_ready, px_ready, sck, mosi, cs_n, busy, done;

  int checks = 0;
  int fails  = 0;

  spi_lcd_framer u0 (
    .clk(clk), .rst(rst), .req_valid(req_valid), .req_ready(req_ready),
    .req_kind(req_kind), .req_arg(req_arg), .half_per(half_per),
    .px_valid(px_valid), .px_ready(px_ready), .px_data(px_data),
    .sck(sck), .mosi(mosi), .cs_n(cs_n), .busy(busy), .done(done)
  );

  always #2 clk = ~clk;

  // link monitor, sampled away from the active edge
  logic        p_cs = 1'b1, p_sck = 1'b1, p_mosi = 1'b0;
  int          nwin = 0, cur_bits = 0, low_run = 0, last_low = 0;
  int          hi_run = 0, min_gap = 1000, done_cnt = 0, bad_mode = 0, bad_ready = 0;
  int          win_bits [8];
  logic [63:0] win_val [8];
  logic [63:0] cur_val = 64'h0;

  always @(negedge clk) begin
    if (!rst) begin
      if (p_cs && !cs_n) begin
        cur_bits = 0; cur_val = 64'h0;
        if (hi_run > 0 && hi_run < min_gap) min_gap = hi_run;
        hi_run = 0;
      end
      if (!cs_n && !p_sck && sck) begin
        cur_val = {cur_val[62:0], mosi}; cur_bits++;
      end
      if (!p_cs && cs_n && nwin < 8) begin
        win_bits[nwin] = cur_bits; win_val[nwin] = cur_val; nwin++;
      end
      if (cs_n && busy) hi_run++;
      if (!busy) hi_run = 0;
      if (!sck) low_run++;
      else if (!p_sck) begin last_low = low_run; low_run = 0; end
      if (!p_sck && sck && mosi != p_mosi) bad_mode++;
      if (cs_n && !sck) bad_mode++;
      if (done) done_cnt++;
      if (req_ready && busy) bad_ready++;
      p_cs = cs_n; p_sck = sck; p_mosi = mosi;
    end
  end

  task automatic chk(input string tag, input logic [63:0] act, input logic [63:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s actual %0h expected %0h", tag, act, exp);
    end
  endtask

  task automatic clear_rec();
    nwin = 0; min_gap = 1000; done_cnt = 0; last_low = 0;
  endtask

  task automatic start_req(input logic [1:0] k, input logic [15:0] a, input logic [7:0] h);
    @(negedge clk);
    req_kind = k; req_arg = a; half_per = h; req_valid = 1'b1;
    @(negedge clk);
    req_valid = 1'b0;
  endtask

  task automatic wait_idle();
    while (busy) @(negedge clk);
    @(negedge clk);
  endtask

  task automatic t_reset();
    chk("R10 cs_n", 64'(cs_n), 64'h1);
    chk("R10 sck", 64'(sck), 64'h1);
    chk("R10 busy", 64'(busy), 64'h0);
    chk("R10 req_ready", 64'(req_ready), 64'h1);
    chk("R10 px_ready", 64'(px_ready), 64'h0);
  endtask

  task automatic t_index();
    clear_rec();
    start_req(2'd0, 16'h113C, 8'd1);
    wait_idle();
    chk("R1 windows", 64'(nwin), 64'd1);
    chk("R4 bit count", 64'(win_bits[0]), 64'd16);
    chk("R1 frame", win_val[0], 64'h703C);
    chk("R9 done pulses", 64'(done_cnt), 64'd1);
  endtask

  task automatic t_data();
    clear_rec();
    start_req(2'd1, 16'h00A5, 8'd2);
    wait_idle();
    chk("R2 frame", win_val[0], 64'h72A5);
    chk("R8 half period 2", 64'(last_low), 64'd2);
  endtask

  task automatic t_regwr(input logic [7:0] h);
    clear_rec();
    start_req(2'd2, 16'h16C8, h);
    wait_idle();
    chk("R5 windows", 64'(nwin), 64'd2);
    chk("R5 index frame", win_val[0], 64'h7016);
    chk("R5 data frame", win_val[1], 64'h72C8);
    chk("R7 gap", 64'(min_gap >= 2 * int'(h)), 64'h1);
    chk("R8 half period", 64'(last_low), 64'(h));
  endtask

  task automatic t_burst3();
    logic [15:0] w [3];
    w[0] = 16'hF800; w[1] = 16'h07E0; w[2] = 16'h801F;
    clear_rec();
    start_req(2'd3, 16'd3, 8'd1);
    for (int i = 0; i < 3; i++) begin
      while (!px_ready) @(negedge clk);
      px_data = w[i]; px_valid = 1'b1;
      @(negedge clk);
      px_valid = 1'b0;
    end
    while (busy) begin
      if (px_ready) bad_ready++;
      @(negedge clk);
    end
    @(negedge clk);
    chk("R6 windows", 64'(nwin), 64'd1);
    chk("R6 bits", 64'(win_bits[0]), 64'd56);
    chk("R6 stream", win_val[0], {8'h00, 8'h72, w[0], w[1], w[2]});
    chk("R6 no extra px_ready", 64'(bad_ready), 64'd0);
  endtask

  task automatic t_burst0();
    clear_rec();
    start_req(2'd3, 16'd0, 8'd1);
    wait_idle();
    chk("R6 empty burst bits", 64'(win_bits[0]), 64'd8);
    chk("R6 empty burst byte", win_val[0], 64'h72);
  endtask

  task automatic t_half_zero();
    clear_rec();
    start_req(2'd0, 16'h0055, 8'd0);
    wait_idle();
    chk("R8 zero acts as one", 64'(last_low), 64'd1);
  endtask

  task automatic t_half_change();
    clear_rec();
    start_req(2'd1, 16'h0033, 8'd2);
    half_per = 8'd5;
    wait_idle();
    chk("R8 latched divider", 64'(last_low), 64'd2);
    chk("R2 frame after change", win_val[0], 64'h7233);
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    fails++;
    $display("FAIL watchdog actual timeout expected completion");
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end

  initial begin
    repeat (4) @(negedge clk);
    rst = 1'b0;
    @(negedge clk);
    t_reset();
    t_index();
    t_data();
    t_regwr(8'd1);
    t_regwr(8'd3);
    t_burst3();
    t_burst0();
    t_half_zero();
    t_half_change();
    chk("R3 mode 3 timing", 64'(bad_mode), 64'd0);
    chk("R9 ready while busy", 64'(bad_ready), 64'd0);
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end
endmodule